// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode code, a short constant field from the instruction and a set of register values into the address of an operand, or into the operand itself when the mode carries a constant. A controller pulses `start` with all inputs valid. For most modes the answer arrives with a one-cycle `done` pulse on the next clock. For the memory-indirect mode the block first issues one read on a simple request/response port and reports `done` once the pointer word has come back.

For the post-increment and pre-decrement modes the block also produces a register writeback: an enable, the register index and the new value, all valid in the same cycle as `done`. The step is the operand size in bytes. Short constant fields are sign-extended to the address width before any addition, except in the absolute and indirect modes, where the field is an unsigned address.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `mem_req`, `wb_en`, `illegal` and `is_imm` are all 0.
- R2: Mode 0 (constant) returns the sign-extended `offset` on `ea` with `is_imm`=1. `done` is high in the cycle after `start`.
- R3: Mode 1 (absolute) returns the zero-extended `offset` on `ea` with `done` in the cycle after `start`.
- R4: Mode 2 (pointer in memory) raises `mem_req` in the cycle after `start`, with `mem_addr` equal to the zero-extended `offset`. Both are held until `mem_rvalid`. `done` is high in the cycle after `mem_rvalid`, with `ea` = `mem_rdata`. A `start` while the read is pending is ignored.
- R5: Mode 3 (program-counter relative) gives `ea` = `pc` + the sign-extended `offset`.
- R6: Mode 4 gives `ea` = `xr` + the sign-extended `offset`. Mode 5 gives `ea` = `br` + the sign-extended `offset`.
- R7: The register modes are: mode 6 gives `ri_val`; mode 7 gives sign-extended `offset` + `ri_val`; mode 8 gives `ri_val` + `rj_val`; mode 9 gives sign-extended `offset` + `ri_val` + `rj_val`.
- R8: Mode 10 (post-increment) gives `ea` = `ri_val` and `wb_val` = `ri_val` + step. The step is 1, 2 or 4 for `size` 0, 1 or 2.
- R9: Mode 11 (pre-decrement) gives `ea` = `wb_val` = `ri_val` − step, wrapping modulo 2^AW.
- R10: `wb_en` is 1 only with `done` of a legal mode 10 or 11, with `wb_idx` = `ri_idx`. For every other mode it stays 0.
- R11: Modes 12 to 15, and modes 10 or 11 with `size` 3, finish in the cycle after `start` with `illegal`=1, `ea`=0 and `wb_en`=0.
- R12: A new `start` is accepted in the cycle right after `done`. Back-to-back operations each produce their own `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Operand size: 0 byte, 1 16-bit, 2 32-bit |
| offset | input | OW | Constant or displacement field |
| ri_val | input | AW | First register operand value |
| rj_val | input | AW | Second register operand value |
| ri_idx | input | RW | Index of the first register |
| pc | input | AW | Program counter value |
| xr | input | AW | Index register value |
| br | input | AW | Base register value |
| mem_req | output | 1 | Pointer read request, held until response |
| mem_addr | output | AW | Pointer read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | AW | Read response data |
| done | output | 1 | Result valid pulse |
| ea | output | AW | Effective address or constant operand |
| is_imm | output | 1 | `ea` carries a constant, not an address |
| illegal | output | 1 | Mode/size combination not supported |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | RW | Register to write back |
| wb_val | output | AW | Updated register value |

## Verification
The bench uses negative displacements against small bases, so a design that zero-extends instead of sign-extending lands far from the expected address. It runs pre-decrement from zero, so the expected value wraps to all ones; a saturating or wrongly ordered decrement would show a different value. Post-increment and pre-decrement are tried at every size, so a wrong step or a pre/post swap shows up as a mismatched `ea` or `wb_val`. The pointer read is held for several cycles with a stray `start` in between, which catches a design that drops the request, moves the address, or takes a second operation. Illegal codes and the size-3 auto modes are checked for a stray writeback.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        M_CONST   = 4'd0,
        M_ABS     = 4'd1,
        M_PTR     = 4'd2,
        M_PCREL   = 4'd3,
        M_XRDISP  = 4'd4,
        M_BRDISP  = 4'd5,
        M_REG     = 4'd6,
        M_REGDISP = 4'd7,
        M_RR      = 4'd8,
        M_RRDISP  = 4'd9,
        M_POSTINC = 4'd10,
        M_PREDEC  = 4'd11
    } mode_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [OW-1:0] offset,
    input  logic [AW-1:0] ri_val,
    input  logic [AW-1:0] rj_val,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] xr,
    input  logic [AW-1:0] br,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb_val,
    output logic          is_imm,
    output logic          illegal,
    output logic          need_mem,
    output logic          wb_en
);
    import ea_pkg::*;

    logic [AW-1:0] disp_s;
    logic [AW-1:0] disp_u;
    logic [AW-1:0] step;
    logic          size_bad;

    generate
        if (OW < AW) begin : g_extend
            assign disp_s = {{(AW-OW){offset[OW-1]}}, offset};
            assign disp_u = {{(AW-OW){1'b0}}, offset};
        end else begin : g_trunc
            assign disp_s = offset[AW-1:0];
            assign disp_u = offset[AW-1:0];
        end
    endgenerate

    always_comb begin
        size_bad = 1'b0;
        case (size)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            2'd2:    step = AW'(4);
            default: begin step = '0; size_bad = 1'b1; end
        endcase
    end

    always_comb begin
        ea       = '0;
        wb_val   = '0;
        is_imm   = 1'b0;
        illegal  = 1'b0;
        need_mem = 1'b0;
        wb_en    = 1'b0;
        case (mode_e'(mode))
            M_CONST:   begin ea = disp_s; is_imm = 1'b1; end
            M_ABS:     ea = disp_u;
            M_PTR:     begin ea = disp_u; need_mem = 1'b1; end
            M_PCREL:   ea = pc + disp_s;
            M_XRDISP:  ea = xr + disp_s;
            M_BRDISP:  ea = br + disp_s;
            M_REG:     ea = ri_val;
            M_REGDISP: ea = ri_val + disp_s;
            M_RR:      ea = ri_val + rj_val;
            M_RRDISP:  ea = ri_val + rj_val + disp_s;
            M_POSTINC: begin
                if (size_bad) illegal = 1'b1;
                else begin
                    ea     = ri_val;
                    wb_val = ri_val + step;
                    wb_en  = 1'b1;
                end
            end
            M_PREDEC: begin
                if (size_bad) illegal = 1'b1;
                else begin
                    ea     = ri_val - step;
                    wb_val = ri_val - step;
                    wb_en  = 1'b1;
                end
            end
            default:   illegal = 1'b1;
        endcase
    end

    always_comb begin
        if (wb_en) a_r10_wb_legal_only: assert (!illegal && !is_imm && !need_mem);
        if (illegal) a_r11_illegal_zero: assert (ea == '0 && !wb_en);
    end
endmodule

// File: rtl/ea_seq.sv
module ea_seq #(
    parameter int AW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] c_ea,
    input  logic [AW-1:0] c_wb_val,
    input  logic          c_is_imm,
    input  logic          c_illegal,
    input  logic          c_need_mem,
    input  logic          c_wb_en,
    input  logic [RW-1:0] ri_idx,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          is_imm,
    output logic          illegal,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [AW-1:0] wb_val
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [AW-1:0] ea;
        logic          imm;
        logic          ill;
        logic          wb;
        logic [RW-1:0] idx;
        logic [AW-1:0] wbv;
        logic [AW-1:0] maddr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wb   = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                if (c_need_mem) begin
                    st_d.busy  = 1'b1;
                    st_d.maddr = c_ea;
                end else begin
                    st_d.done = 1'b1;
                    st_d.ea   = c_ea;
                    st_d.imm  = c_is_imm;
                    st_d.ill  = c_illegal;
                    st_d.wb   = c_wb_en;
                    st_d.idx  = ri_idx;
                    st_d.wbv  = c_wb_val;
                end
            end
        end else if (mem_rvalid) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.ea   = mem_rdata;
            st_d.imm  = 1'b0;
            st_d.ill  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req  = st_q.busy;
    assign mem_addr = st_q.maddr;
    assign done     = st_q.done;
    assign ea       = st_q.ea;
    assign is_imm   = st_q.imm;
    assign illegal  = st_q.ill;
    assign wb_en    = st_q.wb;
    assign wb_idx   = st_q.idx;
    assign wb_val   = st_q.wbv;

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    a_r4_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (done && !mem_req && !wb_en));
    a_r4_no_done_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done);
    a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && !illegal));
    a_r11_illegal_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && !is_imm));
endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
    parameter int AW = 32,
    parameter int OW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [OW-1:0] offset,
    input  logic [AW-1:0] ri_val,
    input  logic [AW-1:0] rj_val,
    input  logic [RW-1:0] ri_idx,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] xr,
    input  logic [AW-1:0] br,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          is_imm,
    output logic          illegal,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [AW-1:0] wb_val
);
    logic [AW-1:0] c_ea, c_wb_val;
    logic          c_is_imm, c_illegal, c_need_mem, c_wb_en;

    ea_calc #(.AW(AW), .OW(OW)) u_calc (
        .mode(mode), .size(size), .offset(offset),
        .ri_val(ri_val), .rj_val(rj_val), .pc(pc), .xr(xr), .br(br),
        .ea(c_ea), .wb_val(c_wb_val), .is_imm(c_is_imm),
        .illegal(c_illegal), .need_mem(c_need_mem), .wb_en(c_wb_en)
    );

    ea_seq #(.AW(AW), .RW(RW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .c_ea(c_ea), .c_wb_val(c_wb_val), .c_is_imm(c_is_imm),
        .c_illegal(c_illegal), .c_need_mem(c_need_mem), .c_wb_en(c_wb_en),
        .ri_idx(ri_idx), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .done(done), .ea(ea),
        .is_imm(is_imm), .illegal(illegal), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_val(wb_val)
    );
endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
    localparam int AW = 32;
    localparam int OW = 16;
    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] mode = '0;
    logic [1:0] size = '0;
    logic [OW-1:0] offset = '0;
    logic [AW-1:0] ri_val = '0, rj_val = '0, pc = '0, xr = '0, br = '0;
    logic [RW-1:0] ri_idx = '0;
    logic mem_rvalid = 1'b0;
    logic [AW-1:0] mem_rdata = '0;
    logic mem_req, done, is_imm, illegal, wb_en;
    logic [AW-1:0] mem_addr, ea, wb_val;
    logic [RW-1:0] wb_idx;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] ea;
        logic          imm;
        logic          ill;
        logic          wb;
        logic [RW-1:0] idx;
        logic [AW-1:0] wbv;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ea_unit #(.AW(AW), .OW(OW), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
        .offset(offset), .ri_val(ri_val), .rj_val(rj_val), .ri_idx(ri_idx),
        .pc(pc), .xr(xr), .br(br), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .ea(ea),
        .is_imm(is_imm), .illegal(illegal), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_val(wb_val)
    );

    function automatic logic [AW-1:0] sx(input logic [OW-1:0] v);
        return AW'($signed(v));
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4/R12: unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " ea"}, ea, e.ea);
                check({e.tag, " is_imm"}, AW'(is_imm), AW'(e.imm));
                check({e.tag, " illegal"}, AW'(illegal), AW'(e.ill));
                check({e.tag, " wb_en (R10)"}, AW'(wb_en), AW'(e.wb));
                if (e.wb) begin
                    check({e.tag, " wb_idx (R10)"}, AW'(wb_idx), AW'(e.idx));
                    check({e.tag, " wb_val"}, wb_val, e.wbv);
                end
            end
        end
    end

    task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic [OW-1:0] off,
                         input logic [AW-1:0] ri, input logic [AW-1:0] rj, input logic [RW-1:0] idx,
                         input logic [AW-1:0] xea, input logic ximm, input logic xill,
                         input logic xwb, input logic [AW-1:0] xwbv, input string tag);
        exp_t e;
        e.ea = xea; e.imm = ximm; e.ill = xill; e.wb = xwb; e.idx = idx; e.wbv = xwbv; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        mode = m; size = s; offset = off; ri_val = ri; rj_val = rj; ri_idx = idx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " done latency"}, AW'(done), AW'(1));
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pc = 32'h0000_1000; xr = 32'h0000_0200; br = 32'h0000_3000;
        repeat (3) @(negedge clk);
        check("R1 done", AW'(done), 0);
        check("R1 mem_req", AW'(mem_req), 0);
        check("R1 wb_en", AW'(wb_en), 0);
        check("R1 illegal", AW'(illegal), 0);
        check("R1 is_imm", AW'(is_imm), 0);
        rst_n = 1'b1;

        issue(4'd0, 2'd0, 16'hFFF0, 0, 0, 0, sx(16'hFFF0), 1, 0, 0, 0, "R2 const neg");
        issue(4'd0, 2'd0, 16'h0123, 0, 0, 0, 32'h123, 1, 0, 0, 0, "R2 const pos");
        issue(4'd1, 2'd0, 16'h8004, 0, 0, 0, 32'h0000_8004, 0, 0, 0, 0, "R3 abs");
        issue(4'd3, 2'd0, 16'hFFF0, 0, 0, 0, 32'h1000 + sx(16'hFFF0), 0, 0, 0, 0, "R5 pcrel neg");
        issue(4'd3, 2'd0, 16'h0040, 0, 0, 0, 32'h1040, 0, 0, 0, 0, "R5 pcrel pos");
        issue(4'd4, 2'd0, 16'h0008, 0, 0, 0, 32'h208, 0, 0, 0, 0, "R6 xr");
        issue(4'd5, 2'd0, 16'h8000, 0, 0, 0, 32'h3000 + sx(16'h8000), 0, 0, 0, 0, "R6 br");
        issue(4'd6, 2'd0, 16'h7777, 32'h100, 32'h20, 3, 32'h100, 0, 0, 0, 0, "R7 reg");
        issue(4'd7, 2'd0, 16'hFFFC, 32'h100, 32'h20, 3, 32'h0FC, 0, 0, 0, 0, "R7 regdisp");
        issue(4'd8, 2'd0, 16'h7777, 32'h100, 32'h20, 3, 32'h120, 0, 0, 0, 0, "R7 rr");
        issue(4'd9, 2'd0, 16'hFFFC, 32'h100, 32'h20, 3, 32'h11C, 0, 0, 0, 0, "R7 rrdisp");
        issue(4'd10, 2'd0, 0, 32'h400, 0, 5, 32'h400, 0, 0, 1, 32'h401, "R8 postinc byte");
        issue(4'd10, 2'd1, 0, 32'h400, 0, 6, 32'h400, 0, 0, 1, 32'h402, "R8 postinc half");
        issue(4'd10, 2'd2, 0, 32'h400, 0, 7, 32'h400, 0, 0, 1, 32'h404, "R8 postinc word");
        issue(4'd11, 2'd2, 0, 32'h400, 0, 9, 32'h3FC, 0, 0, 1, 32'h3FC, "R9 predec word");
        issue(4'd11, 2'd1, 0, 32'h400, 0, 9, 32'h3FE, 0, 0, 1, 32'h3FE, "R9 predec half");
        issue(4'd11, 2'd0, 0, 32'h0, 0, 2, 32'hFFFF_FFFF, 0, 0, 1, 32'hFFFF_FFFF, "R9 predec wrap");
        issue(4'd12, 2'd0, 16'h1234, 32'h55, 0, 1, 0, 0, 1, 0, 0, "R11 code12");
        issue(4'd15, 2'd2, 16'h1234, 32'h55, 0, 1, 0, 0, 1, 0, 0, "R11 code15");
        issue(4'd10, 2'd3, 0, 32'h55, 0, 1, 0, 0, 1, 0, 0, "R11 postinc size3");
        issue(4'd11, 2'd3, 0, 32'h55, 0, 1, 0, 0, 1, 0, 0, "R11 predec size3");

        // R12: back-to-back, start held across two cycles
        begin
            exp_t e1, e2;
            e1.ea = 32'h0000_0011; e1.imm = 0; e1.ill = 0; e1.wb = 0; e1.idx = 0; e1.wbv = 0; e1.tag = "R12 first";
            e2.ea = 32'h0000_0222; e2.imm = 0; e2.ill = 0; e2.wb = 0; e2.idx = 0; e2.wbv = 0; e2.tag = "R12 second";
            sb.push_back(e1); sb.push_back(e2);
            @(negedge clk); mode = 4'd1; offset = 16'h0011; start = 1'b1;
            @(negedge clk); offset = 16'h0222;
            check("R12 first done", AW'(done), 1);
            @(negedge clk); start = 1'b0;
            check("R12 second done", AW'(done), 1);
        end

        // R4: pointer read with delayed response and a stray start
        begin
            exp_t e;
            e.ea = 32'hCAFE_0042; e.imm = 0; e.ill = 0; e.wb = 0; e.idx = 0; e.wbv = 0; e.tag = "R4 ptr";
            sb.push_back(e);
            @(negedge clk); mode = 4'd2; offset = 16'h9010; start = 1'b1;
            @(negedge clk); start = 1'b0;
            check("R4 req raised", AW'(mem_req), 1);
            check("R4 req addr", mem_addr, 32'h0000_9010);
            check("R4 no early done", AW'(done), 0);
            mode = 4'd1; offset = 16'h0001; start = 1'b1;
            @(negedge clk); start = 1'b0;
            check("R4 stray start ignored", AW'(done), 0);
            check("R4 req held", AW'(mem_req), 1);
            check("R4 addr held", mem_addr, 32'h0000_9010);
            @(negedge clk);
            mem_rvalid = 1'b1; mem_rdata = 32'hCAFE_0042;
            @(negedge clk);
            mem_rvalid = 1'b0;
            check("R4 done after resp", AW'(done), 1);
            check("R4 req dropped", AW'(mem_req), 0);
            check("R4 wb_en off (R10)", AW'(wb_en), 0);
            @(negedge clk);
            check("R4 single done", AW'(done), 0);
        end

        repeat (2) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R12: pending results actual=%0d expected=0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule